// File: doc/BRIEF.md
# Serial Peripheral Interrupt Aggregator

This block gathers the single-cycle event pulses of a serial port into one interrupt line. There are thirteen event slots. Nine of them come from named receiver, transmitter and FIFO sources. The other four come from a spare input. Each pulse sets a sticky status bit. Software clears a status bit by writing a one to it.

A mask decides which status bits may raise the interrupt. Software never writes the mask directly. It has two write-only strobes: one sets mask bits and the other clears them. A zero bit in either write leaves the mask alone.

The register interface has one shared write data word and three write strobes: enable, disable and status-clear. A read selector returns either the mask or the status. The interrupt output is a register. It reflects the masked status one clock later.

Top module: `irq_agg_top`

## Requirements
- R1: A write on the enable strobe sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R2: A write on the disable strobe clears every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R3: Enable and disable may be strobed in the same cycle. Every bit set in the shared data then ends up cleared.
- R4: The read selector chooses what `rdData` shows. With `rdSel`=0 it shows the mask. With `rdSel`=1 it shows the status. Both read as zero after reset.
- R5: An event pulse sets its status bit whatever the mask holds. Status bits never fall without a clear write.
- R6: A write on the status-clear strobe clears the status bits whose data bit is 1 and leaves the others set. Writing back a value just read clears exactly those bits.
- R7: An event pulse and a clear of the same status bit may arrive in the same cycle. The bit then stays set.
- R8: Only data bits 12..0 are implemented. Bits 31..13 read as zero, and writes to them are ignored.
- R9: `irqOut` is high in the cycle after some status bit and its mask bit are both set. It is low in the cycle after no such bit exists. It is low after reset.
- R10: The status bit positions are as follows:
  - 0: receive trigger
  - 1: receive empty
  - 2: receive full
  - 3: transmit empty
  - 4: transmit full
  - 5: overrun
  - 6: framing
  - 7: parity
  - 8: timeout
  - 12..9: `evtSpare[3:0]`

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrStrobe | input | 3 | Write strobes: bit 0 enable, bit 1 disable, bit 2 status clear |
| wrData | input | DATA_W | Shared write data |
| rdSel | input | 1 | 0 selects the mask, 1 selects the status |
| rdData | output | DATA_W | Read data, upper bits zero |
| evtRxTrig | input | 1 | Receive trigger pulse |
| evtRxEmpty | input | 1 | Receive empty pulse |
| evtRxFull | input | 1 | Receive full pulse |
| evtTxEmpty | input | 1 | Transmit empty pulse |
| evtTxFull | input | 1 | Transmit full pulse |
| evtOverrun | input | 1 | Overrun pulse |
| evtFraming | input | 1 | Framing error pulse |
| evtParity | input | 1 | Parity error pulse |
| evtTimeout | input | 1 | Receive timeout pulse |
| evtSpare | input | 4 | Spare event pulses for bits 12..9 |
| irqOut | output | 1 | Registered interrupt request |

## Verification
Directed sequences target the collisions one at a time:
- Enable and disable strobed in the same cycle tells disable priority apart from enable priority.
- An event and a clear on the same bit tells set priority apart from clear priority.
- A masked event followed by an idle cycle tells the registered interrupt apart from a combinational one.
- A clear with the just-read value tells a write-one-to-clear register apart from a plain write.

Random strobes, random data with upper bits set, and sparse random events then run against a bench model. They expose any bit that leaks between the mask and the status, or that responds to the unimplemented upper bits.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int FIELD_W = 13;
  localparam int STB_W   = 3;

  // strobe lane positions on wrStrobe
  localparam int STB_ENABLE  = 0;
  localparam int STB_DISABLE = 1;
  localparam int STB_CLEAR   = 2;

  // status bit positions
  localparam int BIT_RXTRIG  = 0;
  localparam int BIT_RXEMPTY = 1;
  localparam int BIT_RXFULL  = 2;
  localparam int BIT_TXEMPTY = 3;
  localparam int BIT_TXFULL  = 4;
  localparam int BIT_OVERRUN = 5;
  localparam int BIT_FRAMING = 6;
  localparam int BIT_PARITY  = 7;
  localparam int BIT_TIMEOUT = 8;
  localparam int BIT_SPARE0  = 9;
  localparam int SPARE_W     = FIELD_W - BIT_SPARE0;

  typedef struct packed {
    logic [FIELD_W-1:0] maskSet;
    logic [FIELD_W-1:0] maskClr;
    logic [FIELD_W-1:0] statClr;
  } ctl_strobe_t;

endpackage

// File: rtl/irq_agg_ctl.sv
module irq_agg_ctl
  import irq_agg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [STB_W-1:0]  wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  output ctl_strobe_t       strobes
);

  logic [FIELD_W-1:0] fieldBits;
  logic [FIELD_W-1:0] clrReq;

  // upper data bits are dropped here, never reach any register
  assign fieldBits = wrData[FIELD_W-1:0];

  always_comb begin
    clrReq          = wrStrobe[STB_DISABLE] ? fieldBits : '0;
    strobes.maskClr = clrReq;
    // disable wins over enable on a shared bit
    strobes.maskSet = wrStrobe[STB_ENABLE] ? (fieldBits & ~clrReq) : '0;
    strobes.statClr = wrStrobe[STB_CLEAR] ? fieldBits : '0;
  end

endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  ctl_strobe_t        strobes,
  input  logic [FIELD_W-1:0] events,
  input  logic               rdSel,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);

  localparam int PAD_W = DATA_W - FIELD_W;

  logic [FIELD_W-1:0] maskReg;
  logic [FIELD_W-1:0] statusReg;
  logic               irqReg;
  logic [FIELD_W-1:0] rdField;

  always_ff @(posedge clk) begin
    if (rst) begin
      maskReg   <= '0;
      statusReg <= '0;
      irqReg    <= 1'b0;
    end else begin
      maskReg   <= (maskReg | strobes.maskSet) & ~strobes.maskClr;
      // event set dominates a clear in the same cycle
      statusReg <= (statusReg & ~strobes.statClr) | events;
      irqReg    <= |(statusReg & maskReg);
    end
  end

  always_comb begin
    rdField = rdSel ? statusReg : maskReg;
    rdData  = {{PAD_W{1'b0}}, rdField};
  end

  assign irqOut = irqReg;

  assert_mask_set_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((maskReg & $past(strobes.maskSet)) == $past(strobes.maskSet)));

  assert_mask_hold_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((maskReg ^ $past(maskReg)) &
               ~($past(strobes.maskSet) | $past(strobes.maskClr))) == '0));

  assert_mask_clr_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((maskReg & $past(strobes.maskClr)) == '0));

  assert_event_latch_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((statusReg & $past(events)) == $past(events)));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(statusReg) & ~statusReg & ~$past(strobes.statClr)) == '0));

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
    ((statusReg & maskReg) != '0) |=> irqOut);

  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (rst)
    ((statusReg & maskReg) == '0) |=> !irqOut);

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  input  logic              evtRxTrig,
  input  logic              evtRxEmpty,
  input  logic              evtRxFull,
  input  logic              evtTxEmpty,
  input  logic              evtTxFull,
  input  logic              evtOverrun,
  input  logic              evtFraming,
  input  logic              evtParity,
  input  logic              evtTimeout,
  input  logic [3:0]        evtSpare,
  output logic              irqOut
);

  ctl_strobe_t        strobes;
  logic [FIELD_W-1:0] evtVec;

  always_comb begin
    evtVec              = '0;
    evtVec[BIT_RXTRIG]  = evtRxTrig;
    evtVec[BIT_RXEMPTY] = evtRxEmpty;
    evtVec[BIT_RXFULL]  = evtRxFull;
    evtVec[BIT_TXEMPTY] = evtTxEmpty;
    evtVec[BIT_TXFULL]  = evtTxFull;
    evtVec[BIT_OVERRUN] = evtOverrun;
    evtVec[BIT_FRAMING] = evtFraming;
    evtVec[BIT_PARITY]  = evtParity;
    evtVec[BIT_TIMEOUT] = evtTimeout;
    for (int i = 0; i < SPARE_W; i++) begin
      evtVec[BIT_SPARE0 + i] = evtSpare[i];
    end
  end

  irq_agg_ctl #(.DATA_W(DATA_W)) uCtl (
    .wrStrobe (wrStrobe),
    .wrData   (wrData),
    .strobes  (strobes)
  );

  irq_agg_dp #(.DATA_W(DATA_W)) uDp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .events  (evtVec),
    .rdSel   (rdSel),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/tb_irq_agg_top.sv
module tb_irq_agg_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    wrStrobe;
  logic [DW-1:0] wrData;
  logic          rdSel;
  logic [DW-1:0] rdData;
  logic          evtRxTrig, evtRxEmpty, evtRxFull, evtTxEmpty, evtTxFull;
  logic          evtOverrun, evtFraming, evtParity, evtTimeout;
  logic [3:0]    evtSpare;
  logic          irqOut;

  int nChecks = 0;
  int nFails  = 0;
  logic finished = 1'b0;

  logic [12:0] mMask, mStatus;
  logic        mIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_agg_top #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData),
    .evtRxTrig(evtRxTrig), .evtRxEmpty(evtRxEmpty), .evtRxFull(evtRxFull),
    .evtTxEmpty(evtTxEmpty), .evtTxFull(evtTxFull), .evtOverrun(evtOverrun),
    .evtFraming(evtFraming), .evtParity(evtParity), .evtTimeout(evtTimeout),
    .evtSpare(evtSpare), .irqOut(irqOut)
  );

  function automatic logic [12:0] nextMask(logic [12:0] m, logic [2:0] s, logic [31:0] d);
    logic [12:0] f = d[12:0];
    logic [12:0] r = m;
    if (s[0]) r = r | f;
    if (s[1]) r = r & ~f;
    return r;
  endfunction

  function automatic logic [12:0] nextStatus(logic [12:0] st, logic [2:0] s,
                                             logic [31:0] d, logic [12:0] e);
    logic [12:0] r = st;
    if (s[2]) r = r & ~d[12:0];
    return r | e;
  endfunction

  task automatic setEvt(input logic [12:0] e);
    evtRxTrig  = e[0];
    evtRxEmpty = e[1];
    evtRxFull  = e[2];
    evtTxEmpty = e[3];
    evtTxFull  = e[4];
    evtOverrun = e[5];
    evtFraming = e[6];
    evtParity  = e[7];
    evtTimeout = e[8];
    evtSpare   = e[12:9];
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readMask(output logic [31:0] v);
    rdSel = 1'b0; #1; v = rdData;
  endtask

  task automatic readStatus(output logic [31:0] v);
    rdSel = 1'b1; #1; v = rdData;
  endtask

  // one clock: drive at negedge, update model, compare after the edge
  task automatic step(input logic [2:0] s, input logic [31:0] d,
                      input logic [12:0] e, input string tag);
    logic [12:0] nM, nS;
    logic        nI;
    logic [31:0] v;
    @(negedge clk);
    wrStrobe = s; wrData = d; setEvt(e);
    nM = nextMask(mMask, s, d);
    nS = nextStatus(mStatus, s, d, e);
    nI = |(mStatus & mMask);
    @(posedge clk); #1;
    mMask = nM; mStatus = nS; mIrq = nI;
    wrStrobe = '0; wrData = '0; setEvt('0);
    readMask(v);   check(v, {19'b0, mMask}, {tag, " mask R1 R2 R3 R4 R8"});
    readStatus(v); check(v, {19'b0, mStatus}, {tag, " status R5 R6 R7 R8"});
    check({31'b0, irqOut}, {31'b0, mIrq}, {tag, " irq R9"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    rst = 1'b1; wrStrobe = '0; wrData = '0; rdSel = 1'b0; setEvt('0);
    mMask = '0; mStatus = '0; mIrq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // reset state R4 R9
    readMask(v);   check(v, 32'h0, "R4 reset mask");
    readStatus(v); check(v, 32'h0, "R4 reset status");
    check({31'b0, irqOut}, 32'h0, "R9 reset irq");

    // R1 and R8: enable with upper junk
    step(3'b001, 32'hFFFF_E005, 13'h0, "R1");
    readMask(v); check(v, 32'h0000_0005, "R8 upper enable bits ignored");
    step(3'b001, 32'h0, 13'h0, "R1 zero write");
    readMask(v); check(v, 32'h0000_0005, "R1 zeros leave mask");
    // R2
    step(3'b010, 32'h1, 13'h0, "R2");
    readMask(v); check(v, 32'h0000_0004, "R2 disable bit0");
    step(3'b010, 32'h0, 13'h0, "R2 zero write");
    readMask(v); check(v, 32'h0000_0004, "R2 zeros leave mask");
    // R3: same-cycle enable+disable
    step(3'b001, 32'h0C0, 13'h0, "R3 pre");
    step(3'b011, 32'h040, 13'h0, "R3");
    readMask(v); check(v, 32'h0000_0084, "R3 disable wins");

    // R9 R10: parity event at bit 7, masked
    step(3'b000, 32'h0, 13'h080, "R10 parity");
    readStatus(v); check(v, 32'h0000_0080, "R10 parity lands in bit 7");
    check({31'b0, irqOut}, 32'h0, "R9 irq not yet high");
    step(3'b000, 32'h0, 13'h0, "R9 idle");
    check({31'b0, irqOut}, 32'h1, "R9 irq one cycle later");
    // R5: unmasked event still latched
    step(3'b000, 32'h0, 13'h001, "R5");
    readStatus(v); check(v, 32'h0000_0081, "R5 unmasked rx trigger latched");
    // R6: write back value read
    readStatus(v);
    step(3'b100, v, 13'h0, "R6 writeback");
    readStatus(v); check(v, 32'h0, "R6 writeback clears observed");
    check({31'b0, irqOut}, 32'h1, "R9 irq still high one cycle");
    step(3'b000, 32'h0, 13'h0, "R9 drop");
    check({31'b0, irqOut}, 32'h0, "R9 irq low after clear");
    // R7: event + clear same bit (timeout, bit 8)
    step(3'b100, 32'h1FF, 13'h100, "R7");
    readStatus(v); check(v, 32'h0000_0100, "R7 event beats clear");
    // R6 partial clear
    step(3'b000, 32'h0, 13'h003, "R6 pre");
    step(3'b100, 32'h1, 13'h0, "R6 partial");
    readStatus(v); check(v, 32'h0000_0102, "R6 only ones cleared");
    // R8: upper-only clear has no effect
    step(3'b100, 32'hFFFF_E000, 13'h0, "R8 clear upper");
    readStatus(v); check(v, 32'h0000_0102, "R8 upper clear ignored");
    // R10: spare bit 12, tx empty bit 3
    step(3'b000, 32'h0, 13'h1008, "R10 spare");
    readStatus(v); check(v, 32'h0000_110A, "R10 spare bit12 and txempty bit3");
    step(3'b100, 32'hFFFF_FFFF, 13'h0, "clear all");

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [2:0]  s = 3'($urandom);
      logic [31:0] d = $urandom;
      logic [12:0] e = 13'($urandom & $urandom & $urandom);
      step(s, d, e, "random");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule